// File: doc/BRIEF.md
# Saturating-Chain Stochastic Function Shaper

This block computes a nonlinear function of a value carried as a random bit stream. The value x in [-1, 1] is in bipolar form: each stream bit is 1 with probability (x+1)/2. The stream drives a saturating up/down state chain with NUM_STATES positions. A 1 moves the chain up one position and a 0 moves it down one. The output bit is decoded from the current position alone.

How the output follows x depends on where the chain spends its time. Two decoding rules are available, selected at run time by `shape`:
- A threshold rule gives an output whose density approximates the bipolar form of tanh(NUM_STATES·x/2).
- A band rule gives an output that approximates exp(-2·EXP_EDGE·|x|): it is near 1 at x = 0 and falls away as |x| grows in either direction.

A larger chain gives a closer fit. For test use, the block carries its own stream generator: a 16-bit LFSR advanced PROB_W steps per cycle and compared against a probability level. It also carries a counter of output ones, so the output density can be read over a window of cycles. Elaboration rejects a state count other than 8, 16, 32 or 64, and a band depth outside 1..NUM_STATES/2-1.

Top module: `sfsm_shaper`

## Requirements
- R1: After reset, `state` equals NUM_STATES/2 and `tally` equals 0.
- R2: On each clock edge where `stream_bit` is 1 and `state` is below NUM_STATES-1, `state` rises by exactly one.
- R3: On each clock edge where `stream_bit` is 0 and `state` is above 0, `state` falls by exactly one.
- R4: `state` holds at NUM_STATES-1 while ones keep arriving, and holds at 0 while zeros keep arriving.
- R5: With `shape` = 0 (threshold rule), `out_bit` is 1 exactly when `state` >= NUM_STATES/2.
- R6: With `shape` = 1 (band rule), `out_bit` is 1 exactly when EXP_EDGE <= `state` <= NUM_STATES-1-EXP_EDGE. It is 0 in the EXP_EDGE positions at each end of the chain.
- R7: `out_bit` depends combinationally on `state` and `shape`: a change of `shape` shows on `out_bit` in the same cycle.
- R8: With `src_sel` = 0 the chain is driven by `ext_bit`. With `src_sel` = 1 it is driven by the internal generator, and `ext_bit` is ignored. `stream_bit` shows the bit in use.
- R9: The generator emits 1 with probability `level`/2^PROB_W. When `level` = 0 it never emits a 1.
- R10: At each clock edge, `tally` goes to 0 when `tally_clr` is 1. Clear takes priority over counting. Otherwise `tally` adds `out_bit`.
- R11: `tally` saturates at 2^CNT_W-1.
- R12: In threshold mode, driven by the generator, the density of output ones over 1024-cycle windows lies within 0.15 of the chain's stationary occupancy of positions >= NUM_STATES/2. This occupancy approximates tanh.
- R13: In band mode, driven by the generator, the density of output ones lies within 0.15 of the stationary occupancy of the middle band. This occupancy approximates the exponential shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shape | input | 1 | Decoding rule: 0 threshold (tanh), 1 band (exponential) |
| src_sel | input | 1 | Stream source: 0 external bit, 1 internal generator |
| level | input | PROB_W | Generator probability numerator over 2^PROB_W |
| ext_bit | input | 1 | External stream bit |
| tally_clr | input | 1 | Clears the ones counter at the next edge |
| stream_bit | output | 1 | Bit currently driving the chain |
| state | output | log2(NUM_STATES) | Current chain position |
| out_bit | output | 1 | Output stream bit |
| tally | output | CNT_W | Count of output ones since last clear |

## Verification
Several input patterns are used, and each separates a different class of fault.
- A steady run of ones, then a steady run of zeros, pushes the chain into both walls. This separates correct saturation from wrap-around.
- A single-step walk through every position, with both decoding rules sampled at each position, pins down the threshold and the band edges exactly. It also shows that a change of rule acts without latency.
- A generator level of zero, with the external bit held at 1, shows that the source select isolates the external pin.
- Generator-driven sweeps at x = -0.5, 0 and +0.5 in both modes compare the measured density with the chain's stationary distribution. These sweeps reveal a wrong direction of travel, a biased generator or an asymmetric band.

// File: rtl/sfsm_pkg.sv
`timescale 1ns/1ps
package sfsm_pkg;

   typedef enum logic {
      SHAPE_TANH = 1'b0,
      SHAPE_EXP  = 1'b1
   } shape_e;

   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_GEN = 1'b1
   } src_e;

   function automatic bit legal_chain_len(input int n);
      return (n == 8) || (n == 16) || (n == 32) || (n == 64);
   endfunction

   function automatic bit legal_band(input int n, input int g);
      return (g >= 1) && (g < n / 2);
   endfunction

endpackage

// File: rtl/sfsm_bitgen.sv
`timescale 1ns/1ps
module sfsm_bitgen #(
   parameter int          PROB_W = 10,
   parameter logic [15:0] SEED   = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PROB_W-1:0] level,
   output logic              bit_o
);
   localparam int LW = 16;

   if (PROB_W < 2 || PROB_W > LW) begin : g_bad_width
      $error("sfsm_bitgen: PROB_W must lie in 2..16");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("sfsm_bitgen: SEED must be nonzero");
   end

   logic [LW-1:0] lfsr_q;
   logic [LW-1:0] lfsr_d;

   // Advance PROB_W steps per cycle so every compare uses fresh bits.
   always_comb begin
      lfsr_d = lfsr_q;
      for (int k = 0; k < PROB_W; k++) begin
         lfsr_d = {lfsr_d[LW-2:0], lfsr_d[15] ^ lfsr_d[14] ^ lfsr_d[12] ^ lfsr_d[3]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lfsr_q <= SEED;
      else        lfsr_q <= lfsr_d;
   end

   assign bit_o = (lfsr_q[PROB_W-1:0] < level);

endmodule

// File: rtl/sfsm_chain.sv
`timescale 1ns/1ps
module sfsm_chain #(
   parameter int NUM_STATES = 16,
   localparam int SW = $clog2(NUM_STATES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_up,
   output logic [SW-1:0] pos
);
   localparam logic [SW-1:0] POS_TOP  = SW'(NUM_STATES - 1);
   localparam logic [SW-1:0] POS_MID  = SW'(NUM_STATES / 2);
   localparam logic [SW-1:0] POS_BASE = '0;

   logic [SW-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= POS_MID;
      end else if (step_up) begin
         if (pos_q != POS_TOP) pos_q <= pos_q + 1'b1;
      end else begin
         if (pos_q != POS_BASE) pos_q <= pos_q - 1'b1;
      end
   end

   assign pos = pos_q;

endmodule

// File: rtl/sfsm_decode.sv
`timescale 1ns/1ps
module sfsm_decode
   import sfsm_pkg::*;
#(
   parameter int NUM_STATES = 16,
   parameter int EXP_EDGE   = 2,
   localparam int SW = $clog2(NUM_STATES)
) (
   input  logic [SW-1:0] pos,
   input  logic          shape,
   output logic          bit_o
);
   localparam int HALF = NUM_STATES / 2;
   localparam int BAND_HI = NUM_STATES - 1 - EXP_EDGE;

   logic [NUM_STATES-1:0] thr_map;
   logic [NUM_STATES-1:0] band_map;

   for (genvar s = 0; s < NUM_STATES; s++) begin : g_map
      if (s >= HALF) begin : g_thr_hi
         assign thr_map[s] = 1'b1;
      end else begin : g_thr_lo
         assign thr_map[s] = 1'b0;
      end
      if (s >= EXP_EDGE && s <= BAND_HI) begin : g_band_in
         assign band_map[s] = 1'b1;
      end else begin : g_band_out
         assign band_map[s] = 1'b0;
      end
   end

   always_comb begin
      if (shape_e'(shape) == SHAPE_EXP) bit_o = band_map[pos];
      else                              bit_o = thr_map[pos];
   end

endmodule

// File: rtl/sfsm_tally.sv
`timescale 1ns/1ps
module sfsm_tally #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hit,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("sfsm_tally: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                   count_q <= '0;
      else if (hit && count_q != CNT_MAX)  count_q <= count_q + 1'b1;
   end

   assign count = count_q;

endmodule

// File: rtl/sfsm_shaper.sv
`timescale 1ns/1ps
module sfsm_shaper
   import sfsm_pkg::*;
#(
   parameter int          NUM_STATES = 16,
   parameter int          EXP_EDGE   = 2,
   parameter int          PROB_W     = 10,
   parameter int          CNT_W      = 11,
   parameter logic [15:0] SEED       = 16'hACE1,
   localparam int SW = $clog2(NUM_STATES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shape,
   input  logic              src_sel,
   input  logic [PROB_W-1:0] level,
   input  logic              ext_bit,
   input  logic              tally_clr,
   output logic              stream_bit,
   output logic [SW-1:0]     state,
   output logic              out_bit,
   output logic [CNT_W-1:0]  tally
);
   if (!legal_chain_len(NUM_STATES)) begin : g_bad_len
      $error("sfsm_shaper: NUM_STATES must be 8, 16, 32 or 64");
   end
   if (!legal_band(NUM_STATES, EXP_EDGE)) begin : g_bad_band
      $error("sfsm_shaper: EXP_EDGE must lie in 1..NUM_STATES/2-1");
   end

   logic gen_bit;

   sfsm_bitgen #(.PROB_W(PROB_W), .SEED(SEED)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .level (level),
      .bit_o (gen_bit)
   );

   assign stream_bit = (src_e'(src_sel) == SRC_GEN) ? gen_bit : ext_bit;

   sfsm_chain #(.NUM_STATES(NUM_STATES)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_up (stream_bit),
      .pos     (state)
   );

   sfsm_decode #(.NUM_STATES(NUM_STATES), .EXP_EDGE(EXP_EDGE)) u_dec (
      .pos   (state),
      .shape (shape),
      .bit_o (out_bit)
   );

   sfsm_tally #(.CNT_W(CNT_W)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tally_clr),
      .hit   (out_bit),
      .count (tally)
   );

endmodule

// File: rtl/sfsm_shaper_chk.sv
`timescale 1ns/1ps
module sfsm_shaper_chk #(
   parameter int NUM_STATES = 16,
   parameter int CNT_W      = 11,
   localparam int SW = $clog2(NUM_STATES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shape,
   input logic             stream_bit,
   input logic [SW-1:0]    state,
   input logic             out_bit,
   input logic             tally_clr,
   input logic [CNT_W-1:0] tally
);
   localparam logic [SW-1:0]    TOP  = SW'(NUM_STATES - 1);
   localparam logic [SW-1:0]    MID  = SW'(NUM_STATES / 2);
   localparam logic [CNT_W-1:0] CMAX = '1;

   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_bit && state != TOP) |=> state == SW'($past(state) + 1'b1));

   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stream_bit && state != '0) |=> state == SW'($past(state) - 1'b1));

   assert_hold_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_bit && state == TOP) |=> state == TOP);

   assert_hold_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stream_bit && state == '0) |=> state == '0);

   assert_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!shape) |-> (out_bit == (state >= MID)));

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tally_clr |=> tally == '0);

   assert_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tally_clr && out_bit && tally != CMAX) |=> tally == CNT_W'($past(tally) + 1'b1));

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tally_clr && tally == CMAX) |=> tally == CMAX);

endmodule

bind sfsm_shaper sfsm_shaper_chk #(.NUM_STATES(NUM_STATES), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .shape      (shape),
   .stream_bit (stream_bit),
   .state      (state),
   .out_bit    (out_bit),
   .tally_clr  (tally_clr),
   .tally      (tally)
);

// File: tb/sim_sfsm_shaper.sv
`timescale 1ns/1ps
module sim_sfsm_shaper;
   localparam int N      = 16;
   localparam int G      = 2;
   localparam int PW     = 10;
   localparam int CW     = 11;
   localparam int SW     = $clog2(N);
   localparam int WIN    = 1024;
   localparam real TOL   = 0.15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          shape = 1'b0;
   logic          src_sel = 1'b0;
   logic [PW-1:0] level = '0;
   logic          ext_bit = 1'b0;
   logic          tally_clr = 1'b0;
   logic          stream_bit;
   logic [SW-1:0] state;
   logic          out_bit;
   logic [CW-1:0] tally;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   sfsm_shaper #(.NUM_STATES(N), .EXP_EDGE(G), .PROB_W(PW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .shape(shape), .src_sel(src_sel), .level(level),
      .ext_bit(ext_bit), .tally_clr(tally_clr), .stream_bit(stream_bit),
      .state(state), .out_bit(out_bit), .tally(tally)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit thr_rule(input int s);
      return s >= N / 2;
   endfunction

   function automatic bit band_rule(input int s);
      return (s >= G) && (s <= N - 1 - G);
   endfunction

   // Stationary occupancy of a saturating birth-death chain, weight r^i.
   function automatic real occupancy(input bit band, input real p);
      real r, w, num, den;
      r = p / (1.0 - p);
      w = 1.0; num = 0.0; den = 0.0;
      for (int i = 0; i < N; i++) begin
         den += w;
         if (band ? band_rule(i) : thr_rule(i)) num += w;
         w = w * r;
      end
      return num / den;
   endfunction

   task automatic t_reset();
      chk(state == SW'(N / 2), "R1 reset state", int'(state), N / 2);
      chk(tally == '0, "R1 reset tally", int'(tally), 0);
      chk(out_bit == 1'b1, "R5 threshold at mid after reset", int'(out_bit), 1);
   endtask

   task automatic t_step();
      src_sel = 1'b0; shape = 1'b0;
      ext_bit = 1'b1; tick();
      chk(state == SW'(N / 2 + 1), "R2 one step up", int'(state), N / 2 + 1);
      ext_bit = 1'b0; tick(); tick();
      chk(state == SW'(N / 2 - 1), "R3 two steps down", int'(state), N / 2 - 1);
      chk(out_bit == 1'b0, "R5 below threshold", int'(out_bit), 0);
      ext_bit = 1'b1; tick();
      chk(out_bit == 1'b1, "R5 at threshold", int'(out_bit), 1);
   endtask

   task automatic t_saturate();
      ext_bit = 1'b1;
      repeat (N + 4) tick();
      chk(state == SW'(N - 1), "R4 hold at top", int'(state), N - 1);
      ext_bit = 1'b0;
      repeat (N + 4) tick();
      chk(state == '0, "R4 hold at base", int'(state), 0);
   endtask

   task automatic t_walk();
      int bad_band = 0;
      int bad_thr  = 0;
      int bad_pos  = 0;
      ext_bit = 1'b1;
      for (int s = 0; s < N; s++) begin
         if (int'(state) != s) bad_pos++;
         shape = 1'b1; #1;
         if (out_bit != band_rule(s)) begin
            bad_band++;
            $display("FAIL R6 band rule at state %0d actual=%0d expected=%0d",
                     s, out_bit, band_rule(s));
         end
         shape = 1'b0; #1;
         if (out_bit != thr_rule(s)) begin
            bad_thr++;
            $display("FAIL R7 rule change at state %0d actual=%0d expected=%0d",
                     s, out_bit, thr_rule(s));
         end
         tick();
      end
      total += 2;
      if (bad_band != 0) bad++;
      if (bad_thr != 0) bad++;
      chk(bad_pos == 0, "R2 walk positions", bad_pos, 0);
   endtask

   task automatic t_source();
      int ones = 0;
      src_sel = 1'b0; ext_bit = 1'b0; #1;
      chk(stream_bit == 1'b0, "R8 external zero", int'(stream_bit), 0);
      ext_bit = 1'b1; #1;
      chk(stream_bit == 1'b1, "R8 external one", int'(stream_bit), 1);
      src_sel = 1'b1; level = '0;
      for (int k = 0; k < N + 4; k++) begin
         #1;
         if (stream_bit) ones++;
         tick();
      end
      chk(ones == 0, "R9 level zero never emits", ones, 0);
      chk(state == '0, "R8 external bit ignored", int'(state), 0);
      src_sel = 1'b0;
   endtask

   task automatic t_tally();
      src_sel = 1'b0; ext_bit = 1'b1; shape = 1'b0;
      repeat (N + 2) tick();
      tally_clr = 1'b1; tick();
      chk(tally == '0, "R10 clear", int'(tally), 0);
      tally_clr = 1'b0;
      repeat (5) tick();
      chk(tally == CW'(5), "R10 counts ones", int'(tally), 5);
      shape = 1'b1;
      repeat (3) tick();
      chk(tally == CW'(5), "R10 zeros not counted", int'(tally), 5);
      shape = 1'b0; tally_clr = 1'b1; tick();
      chk(tally == '0, "R10 clear priority", int'(tally), 0);
      tally_clr = 1'b0;
      repeat ((1 << CW) + 60) tick();
      chk(tally == {CW{1'b1}}, "R11 saturates", int'(tally), (1 << CW) - 1);
   endtask

   task automatic t_sweep(input bit band, input int lvl, input int wins, input string tag);
      real p, expv, got;
      int  sum = 0;
      src_sel = 1'b1; shape = band; level = PW'(lvl);
      repeat (256) tick();
      tally_clr = 1'b1; tick(); tally_clr = 1'b0;
      for (int w = 0; w < wins; w++) begin
         repeat (WIN) tick();
         sum += int'(tally);
         tally_clr = 1'b1; tick(); tally_clr = 1'b0;
      end
      p    = real'(lvl) / real'(1 << PW);
      expv = occupancy(band, p);
      got  = real'(sum) / real'(WIN * wins);
      total++;
      if (got > expv + TOL || got < expv - TOL) begin
         bad++;
         $display("FAIL %s level=%0d actual=%f expected=%f", tag, lvl, got, expv);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_step();
      t_saturate();
      t_walk();
      t_source();
      t_tally();
      t_sweep(1'b0, 256, 8, "R12 threshold x=-0.5");
      t_sweep(1'b0, 512, 8, "R12 threshold x=0");
      t_sweep(1'b0, 768, 8, "R12 threshold x=+0.5");
      t_sweep(1'b1, 256, 8, "R13 band x=-0.5");
      t_sweep(1'b1, 512, 8, "R13 band x=0");
      t_sweep(1'b1, 768, 8, "R13 band x=+0.5");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule